// File: doc/BRIEF.md
# Coincident-Selection RAM Array

A small static memory whose storage is a two-dimensional grid of one-bit cells. A cell is not picked by one large word decoder. A row decoder and a column decoder each pick one line, and a cell responds only where its row line and its column line are both active. The upper address bits feed the row decoder and the lower bits feed the column decoder. Chip select enables only the column decoder. With chip select low, every column line is 0 and no cell in the grid can be reached.

A parameter sets the word width, and with it how the same grid is grouped. With one-bit words, every column line reaches a single cell, so a 4x4 grid holds 16 words of 1 bit. With two-bit words, every column line reaches two neighbouring cells, so the same grid holds 8 words of 2 bits. The write path is synchronous. The read path is combinational: an OR tree collects the selected cells, and the result passes through an output gate that models a tri-state buffer. That gate reports an undriven bus by forcing the data to 0 and lowering a valid flag.

Top module: `cs_ram_array`

## Requirements
- R1: After reset has been applied, every cell holds 0, so every address reads back as 0.
- R2: With one-bit words and a 4x4 grid, `addr[3:2]` selects the row and `addr[1:0]` selects the column. The cell used is row*4+column, so address 4'b1001 reaches cell 9, and each of the 16 addresses holds its own bit.
- R3: While `cs` is low, no cell is written, whatever `we`, `addr` and `din` carry, and `dout_valid` is 0 with `dout` at 0.
- R4: A write changes only the cell or cells where the selected row and the selected column cross. Every other cell keeps its value.
- R5: With `cs` high and `we` low, `dout` shows the selected word and `dout_valid` is 1 in the same cycle, without waiting for a clock edge. A change of `addr` changes `dout` immediately.
- R6: While `cs` and `we` are both high, `dout_valid` is 0 and `dout` is 0.
- R7: With two-bit words, `addr[2:1]` selects the row and `addr[0]` selects one of two column lines. Each column line reaches two adjacent cells, so address 3'b011 reaches cells 6 and 7. `din[0]` and `din[1]` are stored in those two cells separately, and each bit reads back on its own `dout` line.
- R8: A write takes effect on the rising clock edge where `cs` and `we` are both high. A read in the cycle that follows returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Chip select; enables the column decoder |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_BITS+COL_BITS-log2(WORD_W) | Word address; row bits are the upper bits, column bits the lower bits |
| din | input | WORD_W | Write data, one line per bit |
| dout | output | WORD_W | Read data; 0 when not driven |
| dout_valid | output | 1 | 1 when a read is driving `dout` |

## Verification
Read data is combinational, so the bench sets the address and control at a falling edge and samples `dout` and `dout_valid` 1 ns later, before any rising edge occurs. That sample is valid for reads, for the blocked output during a write, and for chip select held low. A write is due at the next rising edge. The bench holds the write through that edge and reads back at the following falling edge. After a write, it reads every address and compares each one against a shadow copy, so any cell that a write disturbed by mistake is reported. Both word widths are instantiated side by side on the same clock.

// File: rtl/csram_pkg.sv
package csram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } csram_op_e;
endpackage

// File: rtl/csram_rst_sync.sv
module csram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/csram_dec.sv
module csram_dec #(
  parameter int IN_W = 2
) (
  input  logic                   en,
  input  logic [IN_W-1:0]        code,
  output logic [(1<<IN_W)-1:0]   lines
);
  always_comb begin
    lines = '0;
    if (en) lines[code] = 1'b1;
  end
endmodule

// File: rtl/csram_grid.sv
module csram_grid #(
  parameter int NR     = 4,
  parameter int NC     = 4,
  parameter int WORD_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NR-1:0]        row_sel,
  input  logic [NC/WORD_W-1:0] col_sel,
  input  logic [WORD_W-1:0]    din,
  output logic [WORD_W-1:0]    rd_bits
);
  localparam int NCL = NC / WORD_W;

  logic [NR-1:0][NC-1:0] cell_q;
  logic [NR-1:0][NC-1:0] cell_d;

  // Next-state: only the row/column intersection takes the data.
  always_comb begin
    cell_d = cell_q;
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < NC; c++) begin
        if (wr_en && row_sel[r] && col_sel[c / WORD_W])
          cell_d[r][c] = din[c % WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= '0;
    else if (wr_en) cell_q <= cell_d;
  end

  // One OR tree per data bit, gathering every cell at that bit position.
  for (genvar b = 0; b < WORD_W; b++) begin : g_or_tree
    always_comb begin
      rd_bits[b] = 1'b0;
      for (int r = 0; r < NR; r++) begin
        for (int l = 0; l < NCL; l++) begin
          rd_bits[b] = rd_bits[b] |
                       (row_sel[r] & col_sel[l] & cell_q[r][l*WORD_W + b]);
        end
      end
    end
  end

  // R4: with no write enabled, the whole grid holds its contents.
  p_grid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cell_q));

  // R2: a write always sees exactly one row line and one column line.
  p_single_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(row_sel) == 1 && $countones(col_sel) == 1));
endmodule

// File: rtl/cs_ram_array.sv
module cs_ram_array
  import csram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int WORD_W   = 1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cs,
  input  logic                                          we,
  input  logic [ROW_BITS+COL_BITS-$clog2(WORD_W)-1:0]   addr,
  input  logic [WORD_W-1:0]                             din,
  output logic [WORD_W-1:0]                             dout,
  output logic                                          dout_valid
);
  localparam int NR   = 1 << ROW_BITS;
  localparam int NC   = 1 << COL_BITS;
  localparam int CDB  = COL_BITS - $clog2(WORD_W);
  localparam int NCL  = 1 << CDB;
  localparam int AW   = ROW_BITS + CDB;

  logic              rst_sync_n;
  csram_op_e         op;
  logic [NR-1:0]     row_sel;
  logic [NCL-1:0]    col_sel;
  logic [WORD_W-1:0] rd_bits;

  csram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    if (!cs)     op = OP_IDLE;
    else if (we) op = OP_WRITE;
    else         op = OP_READ;
  end

  csram_dec #(.IN_W(ROW_BITS)) u_row_dec (
    .en    (1'b1),
    .code  (addr[AW-1 -: ROW_BITS]),
    .lines (row_sel)
  );

  csram_dec #(.IN_W(CDB)) u_col_dec (
    .en    (cs),
    .code  (addr[CDB-1:0]),
    .lines (col_sel)
  );

  csram_grid #(.NR(NR), .NC(NC), .WORD_W(WORD_W)) u_grid (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (op == OP_WRITE),
    .row_sel (row_sel),
    .col_sel (col_sel),
    .din     (din),
    .rd_bits (rd_bits)
  );

  // Output gate standing in for the tri-state buffer.
  always_comb begin
    dout_valid = (op == OP_READ);
    dout       = dout_valid ? rd_bits : '0;
  end

  // R3: chip select low leaves every column line at 0.
  p_col_gated_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs |-> (col_sel == '0));

  // R6 / R3: the output is never driven while writing or deselected.
  p_out_blocked_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cs || we) |-> (!dout_valid && dout == '0));
endmodule

// File: tb/cs_ram_array_tb.sv
module cs_ram_array_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       cs_a, we_a, din_a, dout_a, vld_a;
  logic [3:0] addr_a;
  logic       cs_b, we_b, vld_b;
  logic [2:0] addr_b;
  logic [1:0] din_b, dout_b;

  logic       m16 [16];
  logic [1:0] m8  [8];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cs_ram_array #(.ROW_BITS(2), .COL_BITS(2), .WORD_W(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs_a), .we(we_a), .addr(addr_a),
    .din(din_a), .dout(dout_a), .dout_valid(vld_a));

  cs_ram_array #(.ROW_BITS(2), .COL_BITS(2), .WORD_W(2)) u_dut_w2 (
    .clk(clk), .rst_n(rst_n), .cs(cs_b), .we(we_b), .addr(addr_b),
    .din(din_b), .dout(dout_b), .dout_valid(vld_b));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr16(input int a, input logic d);
    @(negedge clk);
    cs_a = 1; we_a = 1; addr_a = 4'(a); din_a = d;
    #1 chk("R6 output blocked during write", {6'd0, vld_a, dout_a}, 8'd0);
    @(negedge clk);
    cs_a = 0; we_a = 0;
    m16[a] = d;
  endtask

  task automatic rd16(input int a, input string req);
    @(negedge clk);
    cs_a = 1; we_a = 0; addr_a = 4'(a);
    #1 chk(req, {6'd0, vld_a, dout_a}, {6'd0, 1'b1, m16[a]});
  endtask

  task automatic all16(input string req);
    for (int a = 0; a < 16; a++) rd16(a, req);
    @(negedge clk); cs_a = 0;
  endtask

  task automatic wr8(input int a, input logic [1:0] d);
    @(negedge clk);
    cs_b = 1; we_b = 1; addr_b = 3'(a); din_b = d;
    #1 chk("R6 w2 output blocked during write", {5'd0, vld_b, dout_b}, 8'd0);
    @(negedge clk);
    cs_b = 0; we_b = 0;
    m8[a] = d;
  endtask

  task automatic all8(input string req);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      cs_b = 1; we_b = 0; addr_b = 3'(a);
      #1 chk(req, {5'd0, vld_b, dout_b}, {5'd0, 1'b1, m8[a]});
    end
    @(negedge clk); cs_b = 0;
  endtask

  // R1
  task automatic t_reset_state;
    all16("R1 reset clears 16x1");
    all8("R1 reset clears 8x2");
  endtask

  // R3
  task automatic t_cs_low;
    @(negedge clk);
    cs_a = 0; we_a = 1; addr_a = 4'd5; din_a = 1;
    cs_b = 0; we_b = 1; addr_b = 3'd5; din_b = 2'b11;
    #1 chk("R3 deselected output", {6'd0, vld_a, dout_a}, 8'd0);
    chk("R3 deselected w2 output", {5'd0, vld_b, dout_b}, 8'd0);
    @(negedge clk); we_a = 0; we_b = 0;
    all16("R3 no write with cs low");
    all8("R3 no w2 write with cs low");
  endtask

  // R2, R4, R8
  task automatic t_cell9;
    wr16(9, 1'b1);
    rd16(9, "R8 read right after write");
    all16("R4 only cell 9 changed");
    wr16(6, 1'b1);
    all16("R4 only cell 6 added");
    wr16(9, 1'b0);
    all16("R4 clearing cell 9 leaves others");
  endtask

  // R2
  task automatic t_walk16;
    for (int a = 0; a < 16; a++) wr16(a, 1'(((a >> 3) ^ a ^ (a >> 1)) & 1));
    all16("R2 distinct bit per address");
    for (int a = 0; a < 16; a++) wr16(a, ~m16[a]);
    all16("R2 inverted pattern");
  endtask

  // R5
  task automatic t_comb_read;
    @(negedge clk);
    cs_a = 1; we_a = 0; addr_a = 4'd9;
    #1 chk("R5 same-cycle read addr 9", {7'd0, dout_a}, {7'd0, m16[9]});
    addr_a = 4'd8;
    #1 chk("R5 same-cycle read addr 8", {7'd0, dout_a}, {7'd0, m16[8]});
    addr_a = 4'd0;
    #1 chk("R5 same-cycle read addr 0", {6'd0, vld_a, dout_a}, {6'd0, 1'b1, m16[0]});
    @(negedge clk); cs_a = 0;
  endtask

  // R7
  task automatic t_w2;
    wr8(3, 2'b10);
    all8("R7 addr 011 writes only cells 6 and 7");
    wr8(3, 2'b01);
    all8("R7 bits stored separately");
    for (int a = 0; a < 8; a++) wr8(a, 2'((a * 3 + 1) & 3));
    all8("R7 full pattern");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cs_a = 0; we_a = 0; addr_a = '0; din_a = 0;
    cs_b = 0; we_b = 0; addr_b = '0; din_b = '0;
    for (int i = 0; i < 16; i++) m16[i] = 1'b0;
    for (int i = 0; i < 8; i++)  m8[i]  = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset_state;
    t_cs_low;
    t_cell9;
    t_walk16;
    t_comb_read;
    t_w2;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule